// File: doc/BRIEF.md
# Six-Bit Strobed Line Decoder Tree

This block turns a 6-bit address into a 64-bit one-hot select vector. It is built as a two-level tree of nine identical 3-to-8 decode cells. Each cell has a small address store and an output gate with two enables of opposite polarity. The first-level cell decodes address bits 5:3. Each of its eight outputs drives the active-high enable of one second-level cell. The second-level cells decode bits 2:0 and together produce lines 0 to 63.

A single strobe drives the store in every cell, so all six address bits are captured together. While the strobe is low, the stores are open and the select vector follows the live address. When the strobe rises, the address that was present just before the edge is kept. The external enables reach only the first-level cell, which lets them blank the whole vector whatever the store is doing.

The store has two variants, chosen by the parameter `SYNC_CAPTURE`. The default is a level-sensitive transparent latch. The other is an edge-triggered register that loads on each rising clock edge at which the strobe is low. Each store has two named phases:
- `STORE_PASS` (strobe low): the store takes the input.
- `STORE_HOLD` (strobe high): the store keeps its value.

The phase moves from `STORE_PASS` to `STORE_HOLD` when the strobe rises, and back to `STORE_PASS` when it falls.

Top module: `adl_decode_tree`

## Requirements
- R1: With `SYNC_CAPTURE`=0 and the strobe low, the select vector follows the live address with no clock involved.
- R2: When the strobe rises, the address present just before the edge is kept. Address changes while the strobe stays high leave the select vector unchanged.
- R3: All 64 select bits are 0 unless `en_n_i` is 0 and `en_i` is 1 at the same time.
- R4: The enables blank the vector whatever the store phase is. After the enables are restored during a hold, the held line comes back without a new strobe.
- R5: When the block is enabled, exactly one select bit is 1. Address value n sets bit n only, and address bit 0 is the least significant bit.
- R6: Address bits 5:3 choose the group of eight lines 8*k to 8*k+7, and bits 2:0 choose the line within that group. All six bits are captured by the one strobe.
- R7: With `SYNC_CAPTURE`=1, the stored address is 0 while `rst_n` is low, so an enabled block selects line 0.
- R8: With `SYNC_CAPTURE`=1, the store loads on a rising clock edge only when the strobe is low. If the inputs are held stable for each clock period, the output sampled after every edge is the same as in the latch variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered store variant and for the checks |
| rst_n | input | 1 | Active-low reset of the registered store |
| addr_i | input | 6 | Address to decode |
| strobe_i | input | 1 | Store control: 0 = pass the address, 1 = hold it |
| en_n_i | input | 1 | Output enable, active low |
| en_i | input | 1 | Output enable, active high |
| sel_o | output | 64 | One-hot select, active high |

## Verification
Two functions can act in the same cycle: the hold of a captured address and the enable gating. The bench provokes this by changing the address and dropping an enable in the same step while the strobe is high. It then checks for an all-zero vector. Next it restores the enables with a different live address and checks that the held line, not the live one, comes back. Latch and registered variants run side by side on identical stimulus and are judged against the same arithmetic expectation.

// File: rtl/adl_pkg.sv
package adl_pkg;

    // Phase of an address store, derived from the strobe level.
    typedef enum logic {
        STORE_PASS = 1'b0,
        STORE_HOLD = 1'b1
    } store_phase_e;

endpackage

// File: rtl/adl_addr_store.sv
module adl_addr_store
    import adl_pkg::*;
#(
    parameter int W            = 3,
    parameter bit SYNC_CAPTURE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    store_phase_e phase;

    always_comb begin
        phase = strobe_i ? STORE_HOLD : STORE_PASS;
    end

    generate
        if (SYNC_CAPTURE) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_o <= '0;
                end else begin
                    unique case (phase)
                        STORE_PASS: q_o <= d_i;
                        STORE_HOLD: q_o <= q_o;
                    endcase
                end
            end
        end else begin : g_latch
            always_latch begin
                if (phase == STORE_PASS) begin
                    q_o <= d_i;
                end
            end
        end
    endgenerate

    // The store must not move while the strobe stays high.
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && $past(strobe_i)) |-> $stable(q_o));

endmodule

// File: rtl/adl_onehot_gate.sv
module adl_onehot_gate #(
    parameter int W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [(1<<W)-1:0] sel_o
);

    localparam int LINES = 1 << W;

    logic open_gate;

    always_comb begin
        open_gate = !en_n_i && en_i;
    end

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            always_comb begin
                sel_o[i] = open_gate && (a_i == W'(i));
            end
        end
    endgenerate

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!en_n_i && en_i) |-> (sel_o == '0));

    assert_at_most_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    assert_enabled_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n_i && en_i) |-> ($countones(sel_o) == 1));

endmodule

// File: rtl/adl_cell.sv
module adl_cell #(
    parameter int W            = 3,
    parameter bit SYNC_CAPTURE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     addr_i,
    input  logic             strobe_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [(1<<W)-1:0] sel_o
);

    logic [W-1:0] held;

    adl_addr_store #(.W(W), .SYNC_CAPTURE(SYNC_CAPTURE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .d_i      (addr_i),
        .q_o      (held)
    );

    adl_onehot_gate #(.W(W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (held),
        .en_n_i (en_n_i),
        .en_i   (en_i),
        .sel_o  (sel_o)
    );

endmodule

// File: rtl/adl_decode_tree.sv
module adl_decode_tree #(
    parameter int CELL_BITS    = 3,
    parameter bit SYNC_CAPTURE = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*CELL_BITS-1:0]        addr_i,
    input  logic                          strobe_i,
    input  logic                          en_n_i,
    input  logic                          en_i,
    output logic [(1<<(2*CELL_BITS))-1:0] sel_o
);

    localparam int CELL_LINES = 1 << CELL_BITS;

    logic [CELL_LINES-1:0] bank_sel;

    // First level: upper address bits pick one bank, external enables apply here.
    adl_cell #(.W(CELL_BITS), .SYNC_CAPTURE(SYNC_CAPTURE)) u_top_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i[2*CELL_BITS-1:CELL_BITS]),
        .strobe_i (strobe_i),
        .en_n_i   (en_n_i),
        .en_i     (en_i),
        .sel_o    (bank_sel)
    );

    // Second level: one cell per bank, enabled only by its bank line.
    generate
        for (genvar b = 0; b < CELL_LINES; b++) begin : g_bank
            adl_cell #(.W(CELL_BITS), .SYNC_CAPTURE(SYNC_CAPTURE)) u_leaf (
                .clk      (clk),
                .rst_n    (rst_n),
                .addr_i   (addr_i[CELL_BITS-1:0]),
                .strobe_i (strobe_i),
                .en_n_i   (1'b0),
                .en_i     (bank_sel[b]),
                .sel_o    (sel_o[b*CELL_LINES +: CELL_LINES])
            );
        end
    endgenerate

    assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    assert_bank_feeds_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != '0) |-> (bank_sel != '0));

    assert_total_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

endmodule

// File: tb/adl_decode_tree_tb.sv
module adl_decode_tree_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = 6'd0;
    logic        strobe = 1'b1;
    logic        en_n = 1'b0;
    logic        en = 1'b1;
    logic [63:0] sel_l;
    logic [63:0] sel_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [5:0] model_held = 6'd0;

    always #10 clk = ~clk;

    adl_decode_tree #(.CELL_BITS(3), .SYNC_CAPTURE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .strobe_i(strobe),
        .en_n_i(en_n), .en_i(en), .sel_o(sel_l)
    );

    adl_decode_tree #(.CELL_BITS(3), .SYNC_CAPTURE(1'b1)) u_dut_sync (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .strobe_i(strobe),
        .en_n_i(en_n), .en_i(en), .sel_o(sel_s)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_sel();
        if (!en_n && en) return 64'd1 << model_held;
        return 64'd0;
    endfunction

    // Drive at the falling edge, sample 1 ns after the following rising edge.
    task automatic step(input logic [5:0] a, input logic s, input logic n, input logic p);
        @(negedge clk);
        addr = a; strobe = s; en_n = n; en = p;
        if (!s) model_held = a;
        @(posedge clk);
        #1;
    endtask

    task automatic both(input string req);
        check({req, " latch"}, sel_l, expect_sel());
        check({req, " sync"}, sel_s, expect_sel());
    endtask

    initial begin
        // R7: registered store cleared during reset
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset", sel_s, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R5 R6 R8: full sweep with the store open
        for (int a = 0; a < 64; a++) begin
            step(6'(a), 1'b0, 1'b0, 1'b1);
            both("R1 R5 R6 R8 sweep");
            check("R5 count", 64'($countones(sel_l)), 64'd1);
        end

        // R2: capture 37, then move the address while held
        step(6'd37, 1'b0, 1'b0, 1'b1);
        step(6'd37, 1'b1, 1'b0, 1'b1);
        both("R2 capture");
        for (int k = 0; k < 5; k++) begin
            step(6'(k * 13 + 2), 1'b1, 1'b0, 1'b1);
            both("R2 hold");
        end

        // R3 R4: enable and address move together while holding
        step(6'd5, 1'b1, 1'b1, 1'b1);
        both("R3 R4 en_n high");
        step(6'd9, 1'b1, 1'b0, 1'b0);
        both("R3 R4 en low");
        step(6'd60, 1'b1, 1'b1, 1'b0);
        both("R3 R4 both off");
        step(6'd12, 1'b1, 1'b0, 1'b1);
        both("R4 restore held");
        check("R4 held line 37", sel_l, 64'd1 << 37);

        // R3: disabled sweep with the store open
        for (int a = 0; a < 64; a++) begin
            step(6'(a), 1'b0, 1'b0, 1'b0);
            both("R3 disabled sweep");
        end

        // R2 R6: capture the top line, then clear the address
        step(6'd63, 1'b0, 1'b0, 1'b1);
        both("R6 top line");
        step(6'd63, 1'b1, 1'b0, 1'b1);
        step(6'd0, 1'b1, 1'b0, 1'b1);
        both("R2 R6 hold top");
        check("R6 bit 63", sel_l, 64'd1 << 63);

        // R8: reopen and follow a walk across bank boundaries
        for (int a = 7; a < 64; a += 8) begin
            step(6'(a), 1'b0, 1'b0, 1'b1);
            both("R8 bank edge low");
            step(6'(a + 1), 1'b0, 1'b0, 1'b1);
            both("R8 bank edge high");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule